// File: doc/BRIEF.md
# Dual-Side Inter-Processor Messaging Unit

This block joins two processors through a pair of mirrored register windows. Each processor owns one side and reaches it through a simple synchronous 32-bit read/write port. A word that one side places in one of its four outbound word slots shows up in the matching inbound slot of the other side. Per-slot flags tell the sender when the slot is free again and tell the receiver when a word is waiting.

Next to the four word lanes, each direction has four doorbells that carry no data. A side rings a doorbell through its control word, and the peer sees a pending bit that it clears by writing a one to it. Every status flag has an enable bit in the same position of the control word. Each side has one interrupt line, driven from those flags and their enables.

Read data is combinational from the current state. Every side effect, such as clearing a receive flag on a read, takes place at the clock edge that ends the access.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset both control words read 0, both status words read 0x00F0_0000 (all four send-free flags set, nothing else), and both interrupt lines are low.
- R2: With the default layout, outbound slot n is at byte address 4n, inbound slot n at 0x10+4n, status at 0x20 and control at 0x24. Outbound slots, unmapped and unaligned addresses read 0.
- R3: A write to outbound slot n makes the word readable at the peer's inbound slot n, clears the writer's send-free bit 20+(3-n), and sets the peer's receive-full bit 24+(3-n) from the next cycle on.
- R4: A read of inbound slot n clears that side's receive-full bit for n and sets the sender's send-free bit for n again from the next cycle on. A read of an empty slot changes no flag.
- R5: A write to outbound slot n while its send-free bit is 0 replaces the stored word and leaves both flags as they were.
- R6: Writing control with bit 16+(3-n) set raises a request that reads back as 1 in the cycle after the write only. At the edge that ends that cycle, the peer's pending bit 28+(3-n) is set.
- R7: Writing status with bit 28+(3-n) set clears that pending bit. Zero bits and all other status bits have no effect on the write. When a set and a clear coincide, the set wins.
- R8: A side's interrupt is high exactly when some status bit in 31..20 is set together with the control bit in the same position.
- R9: Control bits 31..20 read back as last written. Request bits read 0 once they have been delivered, and control bits 15..0 always read 0.
- R10: The two directions are independent. Both sides can write and read their slots in the same cycle, and each transfer lands without disturbing the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | ADDR_W | Side A byte address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data, valid during the access cycle |
| a_irq | output | 1 | Side A interrupt |
| b_en | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | ADDR_W | Side B byte address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data, valid during the access cycle |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its defaults: 32-bit data, 8-bit addresses and the base register layout. With these values the whole map, including unmapped and unaligned addresses, can be reached with a byte-wide address. The 32-bit width lets every flag, enable and request position be checked against its exact bit. Lockstep random traffic on both sides reaches read/write collisions on one lane, doorbell set/clear collisions and overwrites of full slots, which directed steps would seldom produce together.

// File: rtl/ipc_mu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, field positions and decode types for the
// messaging unit. Assumes four lanes per direction; field positions are
// mirrored so lane n sits at bit (lsb + CH-1-n) of its field.
package ipc_mu_pkg;
    localparam int CH        = 4;
    localparam int CH_IW     = $clog2(CH);
    localparam int BELL_LSB  = 28;
    localparam int FULL_LSB  = 24;
    localparam int FREE_LSB  = 20;
    localparam int RING_LSB  = 16;
    localparam int EN_LSB    = FREE_LSB;
    localparam int EN_W      = 3 * CH;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_RX   = 2'd1,
        RS_STAT = 2'd2,
        RS_CTRL = 2'd3
    } rsel_t;

    // Bit position of lane n inside a field starting at lsb.
    function automatic int fpos(input int lsb, input int n);
        return lsb + (CH - 1 - n);
    endfunction
endpackage

// File: rtl/ipc_mu_decode.sv
`timescale 1ns/1ps
// Module: address decoder for one side. Turns an access into per-lane
// write/read strobes, status/control write strobes and a read selector.
// Assumes word-aligned exact-match decode; anything else selects nothing.
module ipc_mu_decode
    import ipc_mu_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int ALT_MAP = 0
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [CH-1:0]     tx_wr,
    output logic [CH-1:0]     rx_rd,
    output logic              stat_wr,
    output logic              ctrl_wr,
    output rsel_t             rsel,
    output logic [CH_IW-1:0]  ridx
);
    localparam int TX_OFF   = (ALT_MAP != 0) ? 'h20 : 'h00;
    localparam int RX_OFF   = (ALT_MAP != 0) ? 'h40 : 'h10;
    localparam int STAT_OFF = (ALT_MAP != 0) ? 'h60 : 'h20;
    localparam int CTRL_OFF = (ALT_MAP != 0) ? 'h64 : 'h24;

    logic [CH-1:0] tx_hit;
    logic [CH-1:0] rx_hit;
    logic          stat_hit;
    logic          ctrl_hit;

    for (genvar n = 0; n < CH; n++) begin : g_hit
        assign tx_hit[n] = (addr == ADDR_W'(TX_OFF + 4 * n));
        assign rx_hit[n] = (addr == ADDR_W'(RX_OFF + 4 * n));
    end
    assign stat_hit = (addr == ADDR_W'(STAT_OFF));
    assign ctrl_hit = (addr == ADDR_W'(CTRL_OFF));

    assign tx_wr   = tx_hit & {CH{en & we}};
    assign rx_rd   = rx_hit & {CH{en & ~we}};
    assign stat_wr = stat_hit & en & we;
    assign ctrl_wr = ctrl_hit & en & we;

    // Read source selection for the combinational read path.
    always_comb begin
        rsel = RS_NONE;
        ridx = '0;
        for (int n = 0; n < CH; n++) begin
            if (rx_hit[n]) ridx = CH_IW'(n);
        end
        if (en && !we) begin
            if (|rx_hit)       rsel = RS_RX;
            else if (stat_hit) rsel = RS_STAT;
            else if (ctrl_hit) rsel = RS_CTRL;
        end
    end
endmodule

// File: rtl/ipc_mu_word_lane.sv
`timescale 1ns/1ps
// Module: one data lane in one direction. Holds the word and a full flag.
// A write stores the word and marks it full; a read by the receiver empties
// it. A write while full overwrites the word and keeps the flag set.
module ipc_mu_word_lane #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    // Word storage, loaded on every sender write.
    always_ff @(posedge clk) begin
        if (!rst_n)  word <= '0;
        else if (wr) word <= wdata;
    end

    // Full flag: a write fills, a receiver read drains.
    always_ff @(posedge clk) begin
        if (!rst_n)  full <= 1'b0;
        else if (wr) full <= 1'b1;
        else if (rd) full <= 1'b0;
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (full && word == $past(wdata)));                 // R3
    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !full);                                  // R4
    AST_OVERWRITE_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd) |=> full);                           // R5
    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(word));                                  // R5
endmodule

// File: rtl/ipc_mu_bell.sv
`timescale 1ns/1ps
// Module: one doorbell in one direction. A ring strobe raises a one-cycle
// request; the request lands in the receiver's pending bit, which stays set
// until the receiver acknowledges. A landing request wins over an ack.
module ipc_mu_bell (
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic ack,
    output logic req,
    output logic pend
);
    // Request in flight: lives for one cycle after the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= ring;
    end

    // Pending bit at the receiver: set by a landing request, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (req)     pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ring) |=> !req);                                // R6
    AST_REQ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pend);                                           // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !pend);                                // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);                                // R7
endmodule

// File: rtl/ipc_mu_side.sv
`timescale 1ns/1ps
// Module: register window of one side. Decodes the bus access, keeps the
// enable part of the control word, assembles the status word from lane and
// doorbell state, drives read data and the side's interrupt. Assumes
// DATA_W >= 32; the upper part of the write data is passed in as ctl_wd.
module ipc_mu_side
    import ipc_mu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ALT_MAP = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:RING_LSB]         ctl_wd,
    output logic [DATA_W-1:0]          rdata,
    output logic                       irq,
    output logic [CH-1:0]              tx_wr,
    output logic [CH-1:0]              rx_rd,
    output logic [CH-1:0]              ring,
    output logic [CH-1:0]              ack,
    input  logic [CH-1:0]              out_full,
    input  logic [CH-1:0]              in_full,
    input  logic [CH-1:0][DATA_W-1:0]  in_word,
    input  logic [CH-1:0]              in_pend,
    input  logic [CH-1:0]              out_req
);
    logic             stat_wr;
    logic             ctrl_wr;
    rsel_t            rsel;
    logic [CH_IW-1:0] ridx;
    logic [EN_W-1:0]  en_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ctrl_word;

    ipc_mu_decode #(
        .ADDR_W  (ADDR_W),
        .ALT_MAP (ALT_MAP)
    ) u_dec (
        .en      (en),
        .we      (we),
        .addr    (addr),
        .tx_wr   (tx_wr),
        .rx_rd   (rx_rd),
        .stat_wr (stat_wr),
        .ctrl_wr (ctrl_wr),
        .rsel    (rsel),
        .ridx    (ridx)
    );

    // Enable bits of the control word; loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (ctrl_wr) en_q <= ctl_wd[31:EN_LSB];
    end

    // Doorbell ring and acknowledge strobes, one per lane.
    for (genvar n = 0; n < CH; n++) begin : g_bell_strb
        assign ring[n] = ctrl_wr & ctl_wd[fpos(RING_LSB, n)];
        assign ack[n]  = stat_wr & ctl_wd[fpos(BELL_LSB, n)];
    end

    // Status and control words as seen by this side.
    always_comb begin
        stat_word = '0;
        ctrl_word = '0;
        for (int n = 0; n < CH; n++) begin
            stat_word[fpos(BELL_LSB, n)] = in_pend[n];
            stat_word[fpos(FULL_LSB, n)] = in_full[n];
            stat_word[fpos(FREE_LSB, n)] = ~out_full[n];
            ctrl_word[fpos(RING_LSB, n)] = out_req[n];
        end
        ctrl_word[31:EN_LSB] = en_q;
    end

    // Combinational read path.
    always_comb begin
        case (rsel)
            RS_RX:   rdata = in_word[ridx];
            RS_STAT: rdata = stat_word;
            RS_CTRL: rdata = ctrl_word;
            default: rdata = '0;
        endcase
    end

    // Interrupt: any flag with its enable in the same bit position.
    assign irq = |(stat_word[31:EN_LSB] & en_q);

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(en_q));                             // R9
    AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (en_q == $past(ctl_wd[31:EN_LSB])));         // R9
    AST_ONE_READ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_rd));                                        // R2
endmodule

// File: rtl/ipc_msg_unit.sv
`timescale 1ns/1ps
// Module: top of the two-sided messaging unit. Builds two register windows
// and, for each direction, CH word lanes and CH doorbells. Direction d
// carries traffic sent by side d (0 = A, 1 = B) to the other side.
// Assumes one clock and one synchronous reset for both sides.
module ipc_msg_unit
    import ipc_mu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ALT_MAP = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);
    localparam int SIDES = 2;

    logic [SIDES-1:0]                     s_en;
    logic [SIDES-1:0]                     s_we;
    logic [SIDES-1:0][ADDR_W-1:0]         s_addr;
    logic [SIDES-1:0][DATA_W-1:0]         s_wdata;
    logic [SIDES-1:0][DATA_W-1:0]         s_rdata;
    logic [SIDES-1:0]                     s_irq;

    logic [SIDES-1:0][CH-1:0]             tx_wr;
    logic [SIDES-1:0][CH-1:0]             rx_rd;
    logic [SIDES-1:0][CH-1:0]             ring;
    logic [SIDES-1:0][CH-1:0]             ack;
    logic [SIDES-1:0][CH-1:0]             full;
    logic [SIDES-1:0][CH-1:0]             req;
    logic [SIDES-1:0][CH-1:0]             pend;
    logic [SIDES-1:0][CH-1:0][DATA_W-1:0] word;

    assign s_en    = {b_en, a_en};
    assign s_we    = {b_we, a_we};
    assign s_addr  = {b_addr, a_addr};
    assign s_wdata = {b_wdata, a_wdata};
    assign a_rdata = s_rdata[0];
    assign b_rdata = s_rdata[1];
    assign a_irq   = s_irq[0];
    assign b_irq   = s_irq[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        ipc_mu_side #(
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W),
            .ALT_MAP (ALT_MAP)
        ) u_side (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (s_en[s]),
            .we       (s_we[s]),
            .addr     (s_addr[s]),
            .ctl_wd   (s_wdata[s][31:RING_LSB]),
            .rdata    (s_rdata[s]),
            .irq      (s_irq[s]),
            .tx_wr    (tx_wr[s]),
            .rx_rd    (rx_rd[s]),
            .ring     (ring[s]),
            .ack      (ack[s]),
            .out_full (full[s]),
            .in_full  (full[1-s]),
            .in_word  (word[1-s]),
            .in_pend  (pend[1-s]),
            .out_req  (req[s])
        );
    end

    for (genvar d = 0; d < SIDES; d++) begin : g_dir
        for (genvar n = 0; n < CH; n++) begin : g_lane
            ipc_mu_word_lane #(
                .DATA_W (DATA_W)
            ) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .wr    (tx_wr[d][n]),
                .wdata (s_wdata[d]),
                .rd    (rx_rd[1-d][n]),
                .full  (full[d][n]),
                .word  (word[d][n])
            );

            ipc_mu_bell u_bell (
                .clk   (clk),
                .rst_n (rst_n),
                .ring  (ring[d][n]),
                .ack   (ack[1-d][n]),
                .req   (req[d][n]),
                .pend  (pend[d][n])
            );
        end
    end

    AST_DIRS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we) |=> (full[0] != 0 || full[1] != 0 || $past(tx_wr) == 0)); // R10
endmodule

// File: tb/ipc_msg_unit_tb.sv
`timescale 1ns/1ps
module ipc_msg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [7:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // operations for the next cycle, index 0 = side A, 1 = side B
    logic        op_e[2];
    logic        op_we[2];
    logic [7:0]  op_a[2];
    logic [31:0] op_w[2];

    // reference state; direction d = traffic sent by side d
    bit          m_full[2][4];
    logic [31:0] m_data[2][4];
    bit          m_pend[2][4];
    bit          m_req[2][4];
    logic [11:0] m_en[2];

    always #4 clk = ~clk;

    ipc_msg_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    function automatic logic [31:0] exp_status(int s);
        logic [31:0] r = '0;
        for (int n = 0; n < 4; n++) begin
            r[20 + 3 - n] = !m_full[s][n];
            r[24 + 3 - n] = m_full[1-s][n];
            r[28 + 3 - n] = m_pend[1-s][n];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_ctrl(int s);
        logic [31:0] r = '0;
        r[31:20] = m_en[s];
        for (int n = 0; n < 4; n++) r[16 + 3 - n] = m_req[s][n];
        return r;
    endfunction

    function automatic logic [31:0] exp_rdata(int s, logic [7:0] ad);
        for (int n = 0; n < 4; n++)
            if (ad == 8'(8'h10 + 4 * n)) return m_data[1-s][n];
        if (ad == 8'h20) return exp_status(s);
        if (ad == 8'h24) return exp_ctrl(s);
        return 32'h0;
    endfunction

    function automatic logic exp_irq(int s);
        logic [31:0] st = exp_status(s);
        return |(st[31:20] & m_en[s]);
    endfunction

    function automatic string tag_for(logic [7:0] ad);
        if (ad >= 8'h10 && ad <= 8'h1c) return "R3";
        if (ad == 8'h20) return "R4";
        if (ad == 8'h24) return "R6";
        return "R2";
    endfunction

    task automatic check(input string tag, input int s, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s side %0d: actual %h expected %h at %0t", tag, s, act, exp, $time);
        end
    endtask

    task automatic set_op(input int s, input logic we, input logic [7:0] ad, input logic [31:0] wd);
        op_e[s] = 1'b1; op_we[s] = we; op_a[s] = ad; op_w[s] = wd;
    endtask

    task automatic model_update();
        bit          nf[2][4];
        logic [31:0] nd[2][4];
        bit          np[2][4];
        bit          nr[2][4];
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 4; n++) begin
                bit wr, rd, rg, clr;
                wr  = op_e[d] && op_we[d] && op_a[d] == 8'(4 * n);
                rd  = op_e[1-d] && !op_we[1-d] && op_a[1-d] == 8'(8'h10 + 4 * n);
                rg  = op_e[d] && op_we[d] && op_a[d] == 8'h24 && op_w[d][16 + 3 - n];
                clr = op_e[1-d] && op_we[1-d] && op_a[1-d] == 8'h20 && op_w[1-d][28 + 3 - n];
                nf[d][n] = wr || (m_full[d][n] && !rd);
                nd[d][n] = wr ? op_w[d] : m_data[d][n];
                nr[d][n] = rg;
                np[d][n] = m_req[d][n] || (m_pend[d][n] && !clr);
            end
        end
        for (int s = 0; s < 2; s++)
            if (op_e[s] && op_we[s] && op_a[s] == 8'h24) m_en[s] = op_w[s][31:20];
        m_full = nf; m_data = nd; m_pend = np; m_req = nr;
    endtask

    // One lockstep cycle: drive, check reads and interrupts, advance model.
    task automatic step(input string tag);
        @(negedge clk);
        a_en = op_e[0]; a_we = op_we[0]; a_addr = op_a[0]; a_wdata = op_w[0];
        b_en = op_e[1]; b_we = op_we[1]; b_addr = op_a[1]; b_wdata = op_w[1];
        #2;
        for (int s = 0; s < 2; s++) begin
            if (op_e[s] && !op_we[s])
                check((tag != "") ? tag : tag_for(op_a[s]), s,
                      (s == 0) ? a_rdata : b_rdata, exp_rdata(s, op_a[s]));
        end
        check("R8", 0, {31'b0, a_irq}, {31'b0, exp_irq(0)});
        check("R8", 1, {31'b0, b_irq}, {31'b0, exp_irq(1)});
        @(posedge clk);
        model_update();
        for (int s = 0; s < 2; s++) begin
            op_e[s] = 0; op_we[s] = 0; op_a[s] = 0; op_w[s] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2; s++) begin
            op_e[s] = 0; op_we[s] = 0; op_a[s] = 0; op_w[s] = 0;
            m_en[s] = '0;
            for (int n = 0; n < 4; n++) begin
                m_full[s][n] = 0; m_data[s][n] = '0; m_pend[s][n] = 0; m_req[s][n] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        set_op(0, 0, 8'h20, 0); set_op(1, 0, 8'h24, 0); step("R1");
        check("R1", 0, exp_status(0), 32'h00F0_0000);
        set_op(0, 0, 8'h24, 0); set_op(1, 0, 8'h20, 0); step("R1");

        // R2: outbound slots, unmapped and unaligned read 0
        set_op(0, 0, 8'h04, 0); set_op(1, 0, 8'h28, 0); step("R2");
        set_op(0, 0, 8'h21, 0); set_op(1, 0, 8'hFC, 0); step("R2");

        // R3: A sends on lane 1
        set_op(0, 1, 8'h04, 32'hA5A5_0001); step("R3");
        set_op(0, 0, 8'h20, 0); set_op(1, 0, 8'h14, 0); step("R3");
        // R4: flags restored after the read
        set_op(0, 0, 8'h20, 0); set_op(1, 0, 8'h20, 0); step("R4");
        set_op(1, 0, 8'h14, 0); step("R4");   // empty read: no flag change
        set_op(0, 0, 8'h20, 0); step("R4");

        // R5: overwrite while full
        set_op(0, 1, 8'h08, 32'h1111_2222); step("R5");
        set_op(0, 1, 8'h08, 32'h3333_4444); step("R5");
        set_op(0, 0, 8'h20, 0); set_op(1, 0, 8'h20, 0); step("R5");
        set_op(1, 0, 8'h18, 0); step("R5");
        check("R5", 1, m_data[0][2], 32'h3333_4444);

        // R6: ring lane 0 from A, request visible one cycle
        set_op(0, 1, 8'h24, 32'h0008_0000); step("R6");
        set_op(0, 0, 8'h24, 0); set_op(1, 0, 8'h20, 0); step("R6");
        set_op(0, 0, 8'h24, 0); set_op(1, 0, 8'h20, 0); step("R6");

        // R8: enable B's doorbell interrupt for lane 0
        set_op(1, 1, 8'h24, 32'h8000_0000); step("R8");
        step("R8");
        // R7: zero write does nothing, then clear with a one
        set_op(1, 1, 8'h20, 32'h00FF_0000); step("R7");
        set_op(1, 0, 8'h20, 0); step("R7");
        set_op(1, 1, 8'h20, 32'h8000_0000); step("R7");
        set_op(1, 0, 8'h20, 0); step("R7");
        // R7: set and clear in the same cycle, set wins
        set_op(0, 1, 8'h24, 32'h0004_0000); step("R7");
        set_op(1, 1, 8'h20, 32'h4000_0000); step("R7");
        set_op(1, 0, 8'h20, 0); step("R7");

        // R9: control read-back
        set_op(0, 1, 8'h24, 32'hFFFF_FFFF); step("R9");
        set_op(0, 0, 8'h24, 0); step("R9");
        set_op(0, 0, 8'h24, 0); step("R9");
        set_op(0, 1, 8'h24, 32'h0000_0000); set_op(1, 1, 8'h24, 32'h0000_0000); step("R9");

        // R10: both sides send and receive in the same cycles
        set_op(0, 1, 8'h00, 32'hAAAA_0000); set_op(1, 1, 8'h00, 32'hBBBB_0000); step("R10");
        set_op(0, 0, 8'h10, 0); set_op(1, 0, 8'h10, 0); step("R10");
        set_op(0, 0, 8'h20, 0); set_op(1, 0, 8'h20, 0); step("R10");

        // random lockstep traffic
        for (int i = 0; i < 4000; i++) begin
            for (int s = 0; s < 2; s++) begin
                if ($urandom % 10 < 6) begin
                    int k = $urandom % 12;
                    logic [7:0] ad;
                    logic [31:0] wd = $urandom;
                    if (k < 4)       ad = 8'(4 * k);
                    else if (k < 8)  ad = 8'(8'h10 + 4 * (k - 4));
                    else if (k == 8) ad = 8'h20;
                    else if (k == 9) ad = 8'h24;
                    else             ad = 8'($urandom);
                    if (ad == 8'h24 && ($urandom % 3 != 0)) wd = wd & 32'hFFF0_0000;
                    set_op(s, 1'($urandom % 2), ad, wd);
                end
            end
            step("");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule